// File: doc/BRIEF.md
# CAN Controller Low-Power Stop and Wake Sequencer

This block decides when the protocol core of a CAN controller may lose its clock, and when it must get it back. Software writes a small control word holding a stop request, a self-wake enable, an automatic power-save enable and a wake-interrupt mask. The sequencer waits until the frame engine, the buffer mover and the transmit queue are all idle. Only then does it acknowledge the stop and drop the registered clock enable for the core. If halt mode is active when the stop is requested, halt is released first. The bus must then show a run of consecutive recessive bits before the idle check begins.

The sequencer runs on an always-on clock. It samples the receive line on bit-time ticks through a synchronizer, so it can see a recessive-to-dominant edge while the core is unclocked. With self-wake enabled, such an edge clears the stop request and restores the clock. The same edge pulses a start-of-frame hint, which tells the engine to receive the frame without arbitrating. If the wake mask is set, the edge also raises a sticky wake interrupt. A bus-off recovery freeze is held for the whole stop period when stop is entered while bus-off.

In automatic power-save mode, the clock is gated whenever the controller is idle. It is restored when any activity appears or a dominant edge is seen. All pins are plain control and status levels or pulses; no data stream crosses this block, so it has no valid/ready handshake.

Top module: `can_lpm_seq`

## Requirements
- R1: After reset, stop_ack, not_rdy, wake_irq, wake_sof, halt_release, busoff_freeze, stop_bit and self_wake_bit are 0, and core_clk_en is 1.
- R2: While stop_bit is 1, stop_ack stays 0 and core_clk_en stays 1 as long as any of frame_busy, mover_busy or tx_pending is 1. Within 4 cycles of all three being 0, stop_ack becomes 1 and core_clk_en becomes 0.
- R3: Writing stop=0 and self-wake=0 while stopped clears stop_ack and sets core_clk_en back to 1 within 3 cycles.
- R4: A falling edge is a bit_tick sample of 0 on the synchronized rx_in line (2 flops), where the previous bit_tick sample was 1. While stopped with self_wake_bit set, such an edge clears stop_bit and stop_ack and sets core_clk_en. It also pulses wake_sof for exactly one cycle, in the cycle after the tick.
- R5: If a falling edge arrives after stop and self-wake are set but before stop_ack has risen, stop_bit is cleared and stop_ack never rises.
- R6: If halt_in is 1 when a stop begins, halt_release is 1 and stop_ack stays 0 until 11 consecutive bit_tick samples have read recessive. A dominant sample restarts the count. The idle check from R2 follows after that.
- R7: busoff_freeze is 1 exactly while stopped, if bus_off was 1 when the stop was entered. It is 0 otherwise.
- R8: A self-wake sets wake_irq when the wake mask is 1, and leaves it 0 when the mask is 0. wake_irq stays set until a wake_irq_clr pulse.
- R9: A write setting self-wake is taken only while stop_bit and not_rdy are both 0. A write clearing self-wake is always taken.
- R10: With auto power-save set and stop_bit 0, core_clk_en is 0 while all idle inputs are 0. It returns to 1 when any idle input goes to 1, or when a falling edge is seen. After a falling edge it stays 1 until some idle input has been 1 again.
- R11: While stopped with self_wake_bit 0, a falling edge has no effect: stop_ack stays 1, core_clk_en stays 0 and wake_sof stays 0.
- R12: not_rdy is 1 whenever the sequencer is not in normal running state (halt sync, idle wait or stopped), so stop_ack implies not_rdy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_stop | input | 1 | Write data: stop request |
| ctl_self_wake | input | 1 | Write data: self-wake enable |
| ctl_auto_ps | input | 1 | Write data: automatic power-save enable |
| ctl_wake_mask | input | 1 | Write data: wake interrupt mask |
| wake_irq_clr | input | 1 | Clears the wake interrupt |
| frame_busy | input | 1 | A receive or transmit frame is in progress |
| mover_busy | input | 1 | A frame is moving between the serial and message buffers |
| tx_pending | input | 1 | Some buffer holds a pending transmit request |
| halt_in | input | 1 | Controller is in halt mode |
| bus_off | input | 1 | Controller is bus-off |
| rx_in | input | 1 | CAN receive line (asynchronous) |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| stop_bit | output | 1 | Readback of the stop request |
| self_wake_bit | output | 1 | Readback of the self-wake enable |
| stop_ack | output | 1 | Stop has taken effect |
| not_rdy | output | 1 | Sequencer is not in normal running state |
| wake_irq | output | 1 | Sticky wake interrupt |
| wake_sof | output | 1 | Pulse: treat the dominant bit as start-of-frame, receive only |
| halt_release | output | 1 | Asks the engine to leave halt and sync to the bus |
| busoff_freeze | output | 1 | Freezes the bus-off recovery count |
| core_clk_en | output | 1 | Registered clock enable for the protocol core |

## Verification
The bench holds the idle inputs busy in random patterns while a stop is pending. A sequencer that ignored one of them would acknowledge the stop with a frame still moving. It sends a dominant edge before the acknowledge; a design that always reached the stopped state first would raise stop_ack for a cycle. The halt path is given ten recessive bits, then a dominant one, then more recessive bits. A counter that did not restart, or that counted the wrong number, would acknowledge too early. Edges without self-wake and self-wake writes while stopped must change nothing. In power-save mode, the clock must come back on a bare edge and not drop again at once.

// File: rtl/can_lpm_pkg.sv
package can_lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SYNC = 2'd1,
    ST_WAIT = 2'd2,
    ST_STOP = 2'd3
  } lpm_state_t;
endpackage

// File: rtl/can_lpm_rxedge.sv
module can_lpm_rxedge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  input  logic bit_tick,
  output logic smp_rec,
  output logic smp_dom,
  output logic fall_edge
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              rx_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '1;
        else        chain_q <= rx_in;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], rx_in};
    end
  endgenerate

  assign rx_s = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        prev_q <= 1'b1;
    else if (bit_tick) prev_q <= rx_s;

  assign smp_rec   = bit_tick & rx_s;
  assign smp_dom   = bit_tick & ~rx_s;
  assign fall_edge = smp_dom & prev_q;
endmodule

// File: rtl/can_lpm_recsync.sv
module can_lpm_recsync #(
  parameter int NBITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick_rec,
  input  logic tick_dom,
  output logic done
);
  localparam int CW = $clog2(NBITS + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                  cnt_q <= '0;
    else if (clear || tick_dom)                  cnt_q <= '0;
    else if (tick_rec && cnt_q != CW'(NBITS))    cnt_q <= cnt_q + 1'b1;

  assign done = (cnt_q == CW'(NBITS));
endmodule

// File: rtl/can_lpm_ctl.sv
module can_lpm_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wd_stop,
  input  logic wd_sw,
  input  logic wd_aps,
  input  logic wd_wm,
  input  logic hw_clr_stop,
  input  logic not_rdy,
  output logic stop_q,
  output logic sw_q,
  output logic aps_q,
  output logic wm_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      sw_q   <= 1'b0;
      aps_q  <= 1'b0;
      wm_q   <= 1'b0;
    end else begin
      if (hw_clr_stop)  stop_q <= 1'b0;
      else if (wr)      stop_q <= wd_stop;
      if (wr) begin
        aps_q <= wd_aps;
        wm_q  <= wd_wm;
        if (!wd_sw)                    sw_q <= 1'b0;
        else if (!stop_q && !not_rdy)  sw_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_lpm_fsm.sv
module can_lpm_fsm
  import can_lpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_q,
  input  logic sw_q,
  input  logic aps_q,
  input  logic wm_q,
  input  logic idle,
  input  logic halt_in,
  input  logic bus_off,
  input  logic fall_edge,
  input  logic sync_done,
  input  logic irq_clr,
  output logic hw_clr_stop,
  output logic sync_clear,
  output logic stop_ack,
  output logic not_rdy,
  output logic halt_release,
  output logic busoff_freeze,
  output logic wake_sof,
  output logic wake_irq,
  output logic core_clk_en
);
  lpm_state_t state_q, state_d;
  logic wake_ev, hold_q, hold_d, gate_d, en_q, boff_q, sof_q, irq_q;

  assign wake_ev     = stop_q & sw_q & fall_edge;
  assign hw_clr_stop = wake_ev;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (stop_q) state_d = halt_in ? ST_SYNC : ST_WAIT;
      ST_SYNC: if (!stop_q) state_d = ST_RUN; else if (sync_done) state_d = ST_WAIT;
      ST_WAIT: if (!stop_q) state_d = ST_RUN; else if (idle) state_d = ST_STOP;
      ST_STOP: if (!stop_q) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
    if (wake_ev) state_d = ST_RUN;
  end

  always_comb begin
    if (!aps_q || !idle) hold_d = 1'b0;
    else if (fall_edge)  hold_d = 1'b1;
    else                 hold_d = hold_q;
  end

  assign gate_d = aps_q & idle & ~hold_d & (state_d == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      hold_q  <= 1'b0;
      en_q    <= 1'b1;
      boff_q  <= 1'b0;
      sof_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      en_q    <= (state_d != ST_STOP) && !gate_d;
      if (state_q != ST_STOP && state_d == ST_STOP) boff_q <= bus_off;
      sof_q   <= wake_ev;
      if (wake_ev && wm_q) irq_q <= 1'b1;
      else if (irq_clr)    irq_q <= 1'b0;
    end
  end

  assign sync_clear    = (state_q != ST_SYNC);
  assign stop_ack      = (state_q == ST_STOP);
  assign not_rdy       = (state_q != ST_RUN);
  assign halt_release  = (state_q == ST_SYNC);
  assign busoff_freeze = (state_q == ST_STOP) & boff_q;
  assign wake_sof      = sof_q;
  assign wake_irq      = irq_q;
  assign core_clk_en   = en_q;
endmodule

// File: rtl/can_lpm_seq.sv
module can_lpm_seq #(
  parameter int SYNC_BITS   = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_stop,
  input  logic ctl_self_wake,
  input  logic ctl_auto_ps,
  input  logic ctl_wake_mask,
  input  logic wake_irq_clr,
  input  logic frame_busy,
  input  logic mover_busy,
  input  logic tx_pending,
  input  logic halt_in,
  input  logic bus_off,
  input  logic rx_in,
  input  logic bit_tick,
  output logic stop_bit,
  output logic self_wake_bit,
  output logic stop_ack,
  output logic not_rdy,
  output logic wake_irq,
  output logic wake_sof,
  output logic halt_release,
  output logic busoff_freeze,
  output logic core_clk_en
);
  logic smp_rec, smp_dom, fall_edge, sync_done, sync_clear;
  logic hw_clr_stop, aps_q, wm_q, idle;

  assign idle = ~(frame_busy | mover_busy | tx_pending);

  can_lpm_rxedge #(.STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .bit_tick(bit_tick),
    .smp_rec(smp_rec), .smp_dom(smp_dom), .fall_edge(fall_edge)
  );

  can_lpm_recsync #(.NBITS(SYNC_BITS)) u_sync (
    .clk(clk), .rst_n(rst_n), .clear(sync_clear),
    .tick_rec(smp_rec), .tick_dom(smp_dom), .done(sync_done)
  );

  can_lpm_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wd_stop(ctl_stop),
    .wd_sw(ctl_self_wake), .wd_aps(ctl_auto_ps), .wd_wm(ctl_wake_mask),
    .hw_clr_stop(hw_clr_stop), .not_rdy(not_rdy),
    .stop_q(stop_bit), .sw_q(self_wake_bit), .aps_q(aps_q), .wm_q(wm_q)
  );

  can_lpm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .stop_q(stop_bit), .sw_q(self_wake_bit),
    .aps_q(aps_q), .wm_q(wm_q), .idle(idle), .halt_in(halt_in),
    .bus_off(bus_off), .fall_edge(fall_edge), .sync_done(sync_done),
    .irq_clr(wake_irq_clr), .hw_clr_stop(hw_clr_stop), .sync_clear(sync_clear),
    .stop_ack(stop_ack), .not_rdy(not_rdy), .halt_release(halt_release),
    .busoff_freeze(busoff_freeze), .wake_sof(wake_sof), .wake_irq(wake_irq),
    .core_clk_en(core_clk_en)
  );
endmodule

// File: rtl/can_lpm_seq_chk.sv
module can_lpm_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_busy,
  input logic mover_busy,
  input logic tx_pending,
  input logic stop_bit,
  input logic self_wake_bit,
  input logic stop_ack,
  input logic not_rdy,
  input logic wake_irq,
  input logic wake_sof,
  input logic halt_release,
  input logic busoff_freeze,
  input logic core_clk_en
);
  // R2
  ack_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_ack) |-> $past(!frame_busy && !mover_busy && !tx_pending));
  // R2
  ack_gates_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ack |-> !core_clk_en);
  // R12
  ack_not_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ack |-> not_rdy);
  // R7
  freeze_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_freeze |-> stop_ack);
  // R4
  wake_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_sof |-> (!stop_ack && core_clk_en && !stop_bit));
  // R9
  sw_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(self_wake_bit) |-> $past(!stop_bit && !not_rdy));
  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq) |-> wake_sof);
  // R6
  halt_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_release |-> !stop_ack);
endmodule

bind can_lpm_seq can_lpm_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_busy(frame_busy), .mover_busy(mover_busy),
  .tx_pending(tx_pending), .stop_bit(stop_bit), .self_wake_bit(self_wake_bit),
  .stop_ack(stop_ack), .not_rdy(not_rdy), .wake_irq(wake_irq),
  .wake_sof(wake_sof), .halt_release(halt_release),
  .busoff_freeze(busoff_freeze), .core_clk_en(core_clk_en)
);

// File: tb/can_lpm_seq_test.sv
`timescale 1ns/1ps
module can_lpm_seq_test;
  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, ctl_stop = 0, ctl_self_wake = 0, ctl_auto_ps = 0, ctl_wake_mask = 0;
  logic wake_irq_clr = 0, frame_busy = 0, mover_busy = 0, tx_pending = 0;
  logic halt_in = 0, bus_off = 0, rx_in = 1, bit_tick = 0;
  logic stop_bit, self_wake_bit, stop_ack, not_rdy, wake_irq, wake_sof;
  logic halt_release, busoff_freeze, core_clk_en;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  can_lpm_seq uut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic w, input logic a, input logic m);
    @(negedge clk);
    ctl_wr = 1; ctl_stop = s; ctl_self_wake = w; ctl_auto_ps = a; ctl_wake_mask = m;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic tick(input logic v);
    rx_in = v;
    cyc(3);
    bit_tick = 1;
    @(negedge clk);
    bit_tick = 0;
  endtask

  task automatic set_busy(input logic [2:0] p);
    {frame_busy, mover_busy, tx_pending} = p;
  endtask

  function automatic logic exp_ack(input logic [2:0] p);
    return (p == 3'b000);
  endfunction

  initial begin
    cyc(3000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    cyc(2);
    // R1 reset state
    chk("R1 stop_ack", stop_ack, 0); chk("R1 not_rdy", not_rdy, 0);
    chk("R1 clk_en", core_clk_en, 1); chk("R1 irq", wake_irq, 0);
    chk("R1 freeze", busoff_freeze, 0); chk("R1 stop_bit", stop_bit, 0);
    rst_n = 1; cyc(2);
    chk("R1 clk_en after reset", core_clk_en, 1);

    // R2 random busy patterns with stop pending
    for (int i = 0; i < 20; i++) begin
      logic [2:0] p;
      p = 3'($urandom_range(0, 7));
      if (i < 3) p = 3'b001 << i;
      set_busy(p);
      wr(1, 0, 0, 0);
      cyc(5);
      chk("R2 ack vs idle", stop_ack, exp_ack(p));
      chk("R2 clk_en vs idle", core_clk_en, !exp_ack(p));
      chk("R12 not_rdy while stop pending", not_rdy, 1);
      if (p != 0) begin
        set_busy(0); cyc(4);
        chk("R2 ack after idle", stop_ack, 1);
      end
      // R3 release
      wr(0, 0, 0, 0); cyc(3);
      chk("R3 ack cleared", stop_ack, 0);
      chk("R3 clk restored", core_clk_en, 1);
    end

    // R9 set self-wake while stopped is rejected
    wr(1, 0, 0, 0); cyc(4);
    wr(1, 1, 0, 0); cyc(1);
    chk("R9 sw rejected while stopped", self_wake_bit, 0);
    // R11 edge without self-wake ignored
    tick(1); tick(0);
    chk("R11 no sof", wake_sof, 0);
    cyc(2);
    chk("R11 still acked", stop_ack, 1);
    chk("R11 clk off", core_clk_en, 0);
    chk("R11 stop bit kept", stop_bit, 1);
    wr(0, 0, 0, 0); cyc(3);

    // R4 / R8 self-wake with mask
    tick(1);
    wr(1, 1, 0, 1); cyc(4);
    chk("R9 sw accepted", self_wake_bit, 1);
    chk("R4 stopped", stop_ack, 1);
    tick(0);
    chk("R4 sof pulse", wake_sof, 1);
    chk("R4 ack cleared", stop_ack, 0);
    chk("R4 clk on", core_clk_en, 1);
    chk("R4 stop cleared", stop_bit, 0);
    chk("R8 irq set", wake_irq, 1);
    cyc(1);
    chk("R4 sof one cycle", wake_sof, 0);
    @(negedge clk); wake_irq_clr = 1; @(negedge clk); wake_irq_clr = 0;
    chk("R8 irq cleared", wake_irq, 0);
    wr(0, 0, 0, 0);
    chk("R9 sw clear taken", self_wake_bit, 0);

    // R8 no irq when mask clear
    tick(1);
    wr(1, 1, 0, 0); cyc(4);
    tick(0);
    chk("R8 sof without mask", wake_sof, 1);
    chk("R8 no irq unmasked", wake_irq, 0);
    wr(0, 0, 0, 0);

    // R5 immediate edge before acknowledge
    tick(1);
    set_busy(3'b100);
    wr(1, 1, 0, 0); cyc(1);
    tick(0);
    chk("R5 stop cleared", stop_bit, 0);
    set_busy(0); cyc(5);
    chk("R5 ack never", stop_ack, 0);
    chk("R5 clk on", core_clk_en, 1);
    wr(0, 0, 0, 0);

    // R6 halt sync
    tick(1);
    halt_in = 1;
    wr(1, 0, 0, 0); cyc(2);
    chk("R6 halt release", halt_release, 1);
    for (int k = 0; k < 10; k++) tick(1);
    cyc(3);
    chk("R6 no ack after 10", stop_ack, 0);
    tick(0);
    for (int k = 0; k < 10; k++) tick(1);
    cyc(3);
    chk("R6 count restarted", stop_ack, 0);
    tick(1); cyc(3);
    chk("R6 ack after 11", stop_ack, 1);
    halt_in = 0;
    wr(0, 0, 0, 0); cyc(3);

    // R7 bus-off freeze
    bus_off = 1;
    wr(1, 0, 0, 0); cyc(4);
    chk("R7 freeze on", busoff_freeze, 1);
    bus_off = 0; cyc(2);
    chk("R7 freeze held", busoff_freeze, 1);
    wr(0, 0, 0, 0); cyc(2);
    chk("R7 freeze off", busoff_freeze, 0);
    wr(1, 0, 0, 0); cyc(4);
    chk("R7 no freeze", busoff_freeze, 0);
    wr(0, 0, 0, 0); cyc(3);

    // R10 auto power save
    tick(1);
    wr(0, 0, 1, 0); cyc(3);
    chk("R10 gated", core_clk_en, 0);
    chk("R10 not stopped", stop_ack, 0);
    set_busy(3'b010); cyc(2);
    chk("R10 busy restores", core_clk_en, 1);
    set_busy(0); cyc(2);
    chk("R10 regated", core_clk_en, 0);
    tick(0); cyc(1);
    chk("R10 edge restores", core_clk_en, 1);
    cyc(4);
    chk("R10 held after edge", core_clk_en, 1);
    set_busy(3'b001); cyc(2); set_busy(0); cyc(2);
    chk("R10 gated again", core_clk_en, 0);
    wr(0, 0, 0, 0); cyc(2);
    chk("R10 off restores", core_clk_en, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule